// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an 8-bit interval timer that raises a periodic interrupt request. A prescaler runs on the system clock and produces a count strobe at one of eight selectable rates. A counter advances on each strobe. When the counter equals the programmed compare value N, the next strobe returns it to zero and raises a request. Requests therefore repeat every (N+1) strobes, and the counter does not stop between them.

Software controls the timer through a small register port with four addresses: clock select, compare value, mode/control and a status flag. Counting runs only while the enable bit in the mode register is 1 and the remaining mode bits select clear-on-match operation. While the timer is enabled, writes to the compare value are refused. Each refused write is recorded in a sticky error flag.

Top module: `cmi_timer`

## Requirements
- R1: After synchronous active-low reset, all four registers read 00h and `irq` is low.
- R2: Register map: address 0 holds the clock select code in bits 2:0, and bits 7:3 read 0. Address 1 holds the compare value N. Address 2 holds the mode byte as written, with bit 7 as the enable bit. Address 3 bit 0 is the error flag. `rdata` shows the addressed register in the same cycle.
- R3: Clock select codes 0 to 7 give a strobe period of 1, 2, 4, 8, 16, 64, 256 and 1024 system clocks.
- R4: After the clock edge that writes the enable bit, `irq` is first high in the cycle that follows (N+1)·D clock edges, where D is the selected divide ratio.
- R5: After the first request, requests repeat every (N+1)·D cycles. Each request holds `irq` high for exactly one clock cycle when (N+1)·D > 1.
- R6: With N = 00h, a request occurs on every strobe. With D = 1, `irq` therefore stays high on every cycle.
- R7: Counting runs only when mode bits 6:4 and 1:0 are all zero. Bits 3:2 have no effect.
- R8: Clearing the enable bit stops requests and holds both the counter and the prescaler at zero. Enabling again starts a full first interval.
- R9: A compare write made while the enable bit is 1 leaves the compare value unchanged and sets status bit 0. Writing 1 to status bit 0 clears the flag. Writing 0 to it leaves the flag unchanged.
- R10: N = FFh gives an interval of 256·D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request, high for one clock per match |

## Verification
The checker assumes several things about the register port and the enable bit:
- At most one register is written per cycle.
- The compare value changes only through the port.
- The enable bit is the only path that starts or stops counting.

With these in place, the counter can never exceed the compare value while the timer runs. The stimulus follows the same discipline. It programs clock select and compare value only while the timer is disabled. It then enables with a single write to the mode register, and touches the compare register while running only in the directed test that checks the refusal.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CSEL = 2'd0,
      REG_CMP  = 2'd1,
      REG_MODE = 2'd2,
      REG_STAT = 2'd3
   } reg_addr_e;

   localparam int unsigned MODE_EN_BIT   = 7;
   localparam logic [7:0]  MODE_MUST_CLR = 8'b0111_0011;

   // shift amount of the divide ratio selected by a clock-select code
   function automatic int unsigned div_shift(input int unsigned code);
      return (code < 5) ? code : (2 * code - 4);
   endfunction
endpackage

// File: rtl/cmi_regs.sv
module cmi_regs
   import cmi_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [SEL_W-1:0]  csel,
   output logic [CNT_W-1:0]  cmp,
   output logic              enable,
   output logic              run,
   output logic              err
);
   localparam logic [DATA_W-1:0] MUST_CLR = DATA_W'(MODE_MUST_CLR);

   logic [SEL_W-1:0]  csel_q;
   logic [CNT_W-1:0]  cmp_q;
   logic [DATA_W-1:0] mode_q;
   logic              err_q;
   reg_addr_e         sel_reg;

   assign sel_reg = reg_addr_e'(addr);
   assign enable  = mode_q[MODE_EN_BIT];
   assign run     = enable && ((mode_q & MUST_CLR) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csel_q <= '0;
         cmp_q  <= '0;
         mode_q <= '0;
         err_q  <= 1'b0;
      end else if (wr_en) begin
         case (sel_reg)
            REG_CSEL: csel_q <= wdata[SEL_W-1:0];
            REG_CMP: begin
               if (enable) err_q <= 1'b1;
               else        cmp_q <= wdata[CNT_W-1:0];
            end
            REG_MODE: mode_q <= wdata;
            REG_STAT: if (wdata[0]) err_q <= 1'b0;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel_reg)
         REG_CSEL: rdata = {{(DATA_W-SEL_W){1'b0}}, csel_q};
         REG_CMP:  rdata = {{(DATA_W-CNT_W){1'b0}}, cmp_q};
         REG_MODE: rdata = mode_q;
         REG_STAT: rdata = {{(DATA_W-1){1'b0}}, err_q};
         default:  rdata = '0;
      endcase
   end

   assign csel = csel_q;
   assign cmp  = cmp_q;
   assign err  = err_q;
endmodule

// File: rtl/cmi_prescale.sv
module cmi_prescale
   import cmi_pkg::*;
#(
   parameter int unsigned PS_W  = 10,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] csel,
   output logic             strobe
);
   localparam int unsigned N_TAP = 2 ** SEL_W;

   logic [PS_W-1:0]  div_q;
   logic [N_TAP-1:0] tap;

   generate
      if (PS_W < div_shift(N_TAP - 1)) begin : g_bad_width
         $error("cmi_prescale: PS_W too small for largest divide ratio");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) div_q <= '0;
      else                div_q <= div_q + 1'b1;
   end

   generate
      for (genvar k = 0; k < N_TAP; k++) begin : g_tap
         localparam int unsigned     SH   = div_shift(k);
         localparam logic [PS_W-1:0] MASK = PS_W'((64'd1 << SH) - 64'd1);
         assign tap[k] = ((div_q & MASK) == MASK);
      end
   endgenerate

   assign strobe = run && tap[csel];
endmodule

// File: rtl/cmi_count.sv
module cmi_count #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             strobe,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             irq
);
   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (!run) begin
            cnt_q <= '0;
         end else if (strobe) begin
            if (cnt_q == cmp) begin
               cnt_q <= '0;
               irq_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt = cnt_q;
   assign irq = irq_q;
endmodule

// File: rtl/cmi_timer.sv
module cmi_timer #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned PS_W   = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [cmi_pkg::ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic                      irq
);
   generate
      if (CNT_W > DATA_W || SEL_W > DATA_W || DATA_W < 8) begin : g_bad_param
         $error("cmi_timer: register fields exceed data width");
      end
   endgenerate

   logic [SEL_W-1:0] csel_w;
   logic [CNT_W-1:0] cmp_w;
   logic [CNT_W-1:0] cnt_w;
   logic             en_w;
   logic             run_w;
   logic             err_w;
   logic             strobe_w;

   cmi_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .csel(csel_w), .cmp(cmp_w), .enable(en_w),
      .run(run_w), .err(err_w)
   );

   cmi_prescale #(.PS_W(PS_W), .SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_w), .csel(csel_w), .strobe(strobe_w)
   );

   cmi_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_w), .strobe(strobe_w),
      .cmp(cmp_w), .cnt(cnt_w), .irq(irq)
   );
endmodule

// File: rtl/cmi_timer_chk.sv
module cmi_timer_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              irq,
   input logic              run,
   input logic              en,
   input logic              strobe,
   input logic              err,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp
);
   AST_IRQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(strobe)); // R5
   AST_IRQ_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == '0)); // R5
   AST_CNT_WITHIN_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= cmp)); // R4
   AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0) && !irq); // R8
   AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> run); // R7
   AST_CMP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(cmp)); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(wr_en && addr == ADDR_W'(3) && wdata[0])) |=> err); // R9
endmodule

bind cmi_timer cmi_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(cmi_pkg::ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .irq(irq), .run(run_w), .en(en_w), .strobe(strobe_w), .err(err_w),
   .cnt(cnt_w), .cmp(cmp_w)
);

// File: tb/tb_cmi_timer.sv
`timescale 1ns/1ps
module tb_cmi_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   cmi_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .irq(irq));

   always #2.5 clk = ~clk;

   // {select code, compare value}
   localparam int NV = 11;
   localparam logic [10:0] VEC [NV] = '{
      {3'd0, 8'd0},  {3'd0, 8'd5},  {3'd1, 8'd3},  {3'd2, 8'd0},
      {3'd3, 8'd9},  {3'd4, 8'd2},  {3'd5, 8'd1},  {3'd6, 8'd0},
      {3'd7, 8'd1},  {3'd0, 8'd255}, {3'd2, 8'd255}
   };

   function automatic int ratio(input int code);
      case (code)
         0: return 1;    1: return 2;   2: return 4;   3: return 8;
         4: return 16;   5: return 64;  6: return 256; default: return 1024;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      @(negedge clk);
      addr = a;
      #1 d = int'(rdata);
   endtask

   // cycles from the current negedge until irq is seen high; -1 if not within limit
   task automatic wait_irq(input int limit, output int t);
      t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!irq && t < limit);
      if (!irq) t = -1;
   endtask

   initial begin
      #(150000 * 5);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v, t, t2, exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", int'(irq), 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 reg", v, 0);
      end

      // R2 register map readback
      wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 csel", v, 8'h07);
      wr(2'd1, 8'hA5); rd(2'd1, v); check("R2 cmp", v, 8'hA5);
      wr(2'd2, 8'h0C); rd(2'd2, v); check("R2 mode", v, 8'h0C);
      rd(2'd3, v); check("R2 stat", v, 0);
      wr(2'd2, 8'h00);

      // table walk: R3 R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         int sel, n;
         sel = int'(VEC[i][10:8]);
         n   = int'(VEC[i][7:0]);
         exp = (n + 1) * ratio(sel);
         wr(2'd2, 8'h00);
         wr(2'd0, 8'(sel));
         wr(2'd1, 8'(n));
         wr(2'd2, 8'h80);
         wait_irq(exp + 8, t);
         check(n == 255 ? "R10 first" : (n == 0 ? "R6 first" : "R4 first"), t, exp);
         wait_irq(exp + 8, t2);
         check(sel > 0 ? "R3 period" : "R5 period", t2, exp);
         if (exp > 1) begin
            @(negedge clk);
            check("R5 width", int'(irq), 0);
         end
      end
      wr(2'd2, 8'h00);

      // R7 mode gate
      wr(2'd0, 8'd0); wr(2'd1, 8'd0);
      wr(2'd2, 8'h90);
      wait_irq(40, t); check("R7 bit4 blocks", t, -1);
      wr(2'd2, 8'h81);
      wait_irq(40, t); check("R7 bit0 blocks", t, -1);
      wr(2'd2, 8'h8C);
      wait_irq(40, t); check("R7 bits3:2 ignored", t, 1);
      wr(2'd2, 8'h00);

      // R9 compare write while enabled
      wr(2'd1, 8'd3);
      wr(2'd2, 8'h80);
      wr(2'd1, 8'h10);
      rd(2'd1, v); check("R9 cmp held", v, 3);
      rd(2'd3, v); check("R9 err set", v, 1);
      wait_irq(40, t);
      wait_irq(40, t); check("R9 period kept", t, 4);
      wr(2'd3, 8'h00);
      rd(2'd3, v); check("R9 zero write keeps", v, 1);
      wr(2'd3, 8'h01);
      rd(2'd3, v); check("R9 err cleared", v, 0);
      wr(2'd2, 8'h00);

      // R8 stop and restart
      wr(2'd0, 8'd2); wr(2'd1, 8'd5);
      wr(2'd2, 8'h80);
      repeat (15) @(negedge clk);
      wr(2'd2, 8'h00);
      wait_irq(100, t); check("R8 stopped", t, -1);
      wr(2'd2, 8'h80);
      wait_irq(100, t); check("R8 full restart", t, 24);
      wr(2'd2, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule